// File: doc/BRIEF.md
# Grayscale Pixel Point-Operation Unit

This block transforms a stream of 8-bit grayscale pixels, one pixel per clock, with a per-pixel operation chosen by a 2-bit mode. Four operations are available. Brighten adds a runtime amount. Darken subtracts that amount. Binarize snaps the pixel to full black or full white against a runtime threshold. Invert produces the photographic negative. Brighten and darken clamp at the ends of the range, so the result never wraps.

The unit is a single registered stage. An input pixel is taken when the input strobe is high, and its result appears with a matching output strobe one clock later. The mode, amount and threshold are captured together with the pixel they apply to, so a host can switch operations between any two pixels of a stream without a bubble. When no pixel is offered, the output register keeps its last value.

Top module: `pix_point_op`

## Requirements
- R1: A synchronous active-high reset drives the output pixel to 0 and the output strobe low on the next clock edge, and it overrides a pixel offered in the same cycle.
- R2: The output strobe is high in exactly the cycle after an accepted input (input strobe high), and low after a cycle without one.
- R3: Mode 2'b00 (brighten) yields min(pixel + amount, 255).
- R4: Mode 2'b01 (darken) yields max(pixel - amount, 0).
- R5: Mode 2'b10 (binarize) yields 255 when pixel >= threshold and 0 otherwise.
- R6: Mode 2'b11 (invert) yields 255 - pixel.
- R7: Mode, amount and threshold are captured in the same cycle as the pixel, so a change affects only the pixel offered alongside it and those after it.
- R8: A cycle with the input strobe low leaves the output pixel unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel offered this cycle |
| in_pix | input | 8 | Input grayscale pixel |
| in_mode | input | 2 | Operation select (00 brighten, 01 darken, 10 binarize, 11 invert) |
| in_amount | input | 8 | Brightness adjustment amount |
| in_thresh | input | 8 | Binarization threshold |
| out_valid | output | 1 | Result valid strobe |
| out_pix | output | 8 | Processed pixel |

## Verification
Two events can land in the same clock: a mode change and the pixel it first applies to. A reset can also arrive while a pixel is offered. The bench changes mode, amount and threshold on every cycle of a back-to-back burst and expects each result to follow its own cycle's controls, with no carry-over from the previous pixel. It also raises reset together with a valid pixel and expects a zero pixel and a low strobe after that edge. The exhaustive pixel sweeps over several amounts and thresholds run the clamp edges at 0 and 255 and the equal-to-threshold case.

// File: rtl/pix_op_pkg.sv
package pix_op_pkg;

  typedef enum logic [1:0] {
    OP_BRIGHTEN = 2'b00,
    OP_DARKEN   = 2'b01,
    OP_BINARIZE = 2'b10,
    OP_INVERT   = 2'b11
  } pix_op_e;

endpackage

// File: rtl/pix_clamp_addsub.sv
// Saturating add / subtract of an amount to a pixel.
module pix_clamp_addsub #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] amount,
  output logic [PIX_W-1:0] up,
  output logic [PIX_W-1:0] down
);
  localparam int EXT_W = PIX_W + 1;
  localparam logic [PIX_W-1:0] FULL = {PIX_W{1'b1}};

  logic [EXT_W-1:0] sum;
  logic [EXT_W-1:0] diff;

  always_comb begin
    sum  = {1'b0, pix} + {1'b0, amount};
    diff = {1'b0, pix} - {1'b0, amount};
    // carry out means the sum passed full scale
    up   = sum[EXT_W-1]  ? FULL          : sum[PIX_W-1:0];
    // borrow means the difference went below zero
    down = diff[EXT_W-1] ? '0            : diff[PIX_W-1:0];
  end
endmodule

// File: rtl/pix_level_ops.sv
// Threshold binarization and negative.
module pix_level_ops #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] thresh,
  output logic [PIX_W-1:0] bin,
  output logic [PIX_W-1:0] neg
);
  localparam logic [PIX_W-1:0] FULL = {PIX_W{1'b1}};

  always_comb begin
    bin = (pix >= thresh) ? FULL : '0;
    neg = FULL - pix;
  end
endmodule

// File: rtl/pix_point_op.sv
module pix_point_op
  import pix_op_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [PIX_W-1:0]  in_amount,
  input  logic [PIX_W-1:0]  in_thresh,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix
);
  localparam logic [PIX_W-1:0] FULL = {PIX_W{1'b1}};

  logic [PIX_W-1:0] r_up, r_down, r_bin, r_neg;
  logic [PIX_W-1:0] result;
  pix_op_e          op;

  pix_clamp_addsub #(.PIX_W(PIX_W)) u_addsub (
    .pix    (in_pix),
    .amount (in_amount),
    .up     (r_up),
    .down   (r_down)
  );

  pix_level_ops #(.PIX_W(PIX_W)) u_level (
    .pix    (in_pix),
    .thresh (in_thresh),
    .bin    (r_bin),
    .neg    (r_neg)
  );

  always_comb begin
    op = pix_op_e'(in_mode[1:0]);
    unique case (op)
      OP_BRIGHTEN: result = r_up;
      OP_DARKEN:   result = r_down;
      OP_BINARIZE: result = r_bin;
      OP_INVERT:   result = r_neg;
      default:     result = r_neg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= result;
    end
  end

  // R1: reset wins over an offered pixel
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_pix == '0));

  // R2: strobe follows an accepted input by one clock
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3: brighten never lowers the pixel
  p_no_wrap_up_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == OP_BRIGHTEN) |=> out_pix >= $past(in_pix));

  // R4: darken never raises the pixel
  p_no_wrap_dn_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == OP_DARKEN) |=> out_pix <= $past(in_pix));

  // R5: binarize produces only the two extreme levels
  p_bin_levels_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == OP_BINARIZE) |=> (out_pix == '0 || out_pix == FULL));

  // R8: output held while no pixel is offered
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_pix));

endmodule

// File: tb/tb_pix_point_op.sv
`timescale 1ns/1ps
module tb_pix_point_op;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_pix = '0;
  logic [1:0] in_mode = '0;
  logic [7:0] in_amount = '0;
  logic [7:0] in_thresh = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pix_point_op dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
    .in_mode(in_mode), .in_amount(in_amount), .in_thresh(in_thresh),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic int model(int p, int m, int a, int t);
    case (m)
      0: return (p + a > 255) ? 255 : p + a;
      1: return (p - a < 0) ? 0 : p - a;
      2: return (p >= t) ? 255 : 0;
      default: return 255 - p;
    endcase
  endfunction

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // offer one pixel at a falling edge, check it at the next falling edge
  task automatic push(input int p, input int m, input int a, input int t, input string req);
    in_valid  = 1'b1;
    in_pix    = 8'(p);
    in_mode   = 2'(m);
    in_amount = 8'(a);
    in_thresh = 8'(t);
    @(negedge clk);
    check(int'(out_valid), 1, "R2");
    check(int'(out_pix), model(p, m, a, t), req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int amts[5] = '{0, 1, 37, 128, 255};
    int ths[4]  = '{0, 1, 128, 255};
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check(int'(out_valid), 0, "R1");
    check(int'(out_pix), 0, "R1");
    rst = 1'b0;

    // R3 / R4: saturating brighten and darken, all pixels
    foreach (amts[i]) begin
      for (int p = 0; p < 256; p++) push(p, 0, amts[i], 0, "R3");
      for (int p = 0; p < 256; p++) push(p, 1, amts[i], 0, "R4");
    end
    // R5: binarize, including pixel equal to threshold
    foreach (ths[i])
      for (int p = 0; p < 256; p++) push(p, 2, 0, ths[i], "R5");
    // R6: invert
    for (int p = 0; p < 256; p++) push(p, 3, 0, 0, "R6");

    // R7: controls change every cycle of a back-to-back burst
    for (int k = 0; k < 64; k++)
      push((k * 53) % 256, k % 4, (k * 29) % 256, (k * 71) % 256, "R7");

    // R8: idle cycles leave the pixel alone while inputs wander
    push(100, 0, 20, 0, "R8");
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      in_pix = 8'(k * 60); in_mode = 2'(k); in_amount = 8'(k * 9); in_thresh = 8'(k);
      @(negedge clk);
      check(int'(out_valid), 0, "R2");
      check(int'(out_pix), 120, "R8");
    end

    // R1: reset raised together with a valid pixel
    push(10, 3, 0, 0, "R6");
    rst = 1'b1; in_valid = 1'b1; in_pix = 8'd5; in_mode = 2'd0;
    @(negedge clk);
    check(int'(out_valid), 0, "R1");
    check(int'(out_pix), 0, "R1");
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check(int'(out_valid), 0, "R2");
    finish_run();
  end

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule